// File: doc/BRIEF.md
# UTOPIA Level 2 Multi-PHY Cell Transmitter

This block is the PHY-side end of a UTOPIA Level 2 multi-PHY bus. An ATM-layer master polls it and reads cells from it. The block collects one complete 53-byte cell from an internal source, one byte per handshake. It answers the master's polls with a cell-available flag. Once the master has selected it, the block streams the cell out byte by byte, and it flags the first byte with start-of-cell.

The master drives an active-low address strobe and an active-low read enable. The port becomes selected only at the clock edge where the enable falls, and only if the address strobe is low at that edge. Every bus output is modelled as a value plus an output-enable, so that the tristate buses can be built outside this block. All logic runs on the bus clock. The bus clock is rated up to 33 MHz with a 45%–55% duty cycle.

The cell source is a valid/ready stream. A byte moves when both `src_valid` and `src_ready` are high. The block applies back-pressure by holding `src_ready` low from the moment a whole cell is stored until the cell's last byte has been sent. The source must then hold its byte and keep `src_valid` asserted until the block accepts it.

Top module: `utl2_cell_tx`

## Requirements
- R1: `clav_oe` is 1 in a cycle exactly when `addr_n` was sampled low at the previous rising edge, and 0 otherwise.
- R2: `clav_o` is 1 only while `clav_oe` is 1 and a complete 53-byte cell is stored and not yet fully sent. It stays 0 while fewer than 53 bytes are stored.
- R3: The port becomes selected at an edge where `enable_n` goes from 1 to 0 while `addr_n` is 0. If `addr_n` is 1 at such an edge, the port is left deselected and no later cycle drives the data bus until a new qualifying edge.
- R4: `data_oe` and `soc_oe` are 1 in a cycle exactly when the previous edge saw `enable_n` low with the port selected. If no cell is stored, `data_o` is 0 in such a cycle.
- R5: `soc_o` is 1 together with byte 0 of each cell and 0 with every other byte.
- R6: Each transfer cycle presents the next byte in the order the bytes were received. When enable is released, or the port is deselected, in mid-cell, the byte position is kept and output resumes at the next byte once the port is selected again.
- R7: After the last byte (byte 52) has appeared, `clav_o` reads 0 in the following cycle when `addr_n` is low.
- R8: `src_ready` is 1 exactly when no complete cell is stored. A byte is stored when `src_valid` and `src_ready` are both 1 at an edge. Bytes offered while `src_ready` is 0 are not taken.
- R9: After reset, all output enables are 0, no cell is stored, `src_ready` is 1 and the port is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_data | input | 8 | Cell byte from source |
| src_valid | input | 1 | Source byte valid |
| src_ready | output | 1 | Block can accept a source byte |
| addr_n | input | 1 | Active-low address strobe from master |
| enable_n | input | 1 | Active-low read enable from master |
| clav_o | output | 1 | Cell-available value |
| clav_oe | output | 1 | Cell-available drive enable |
| soc_o | output | 1 | Start-of-cell value |
| soc_oe | output | 1 | Start-of-cell drive enable |
| data_o | output | 8 | Cell data value |
| data_oe | output | 1 | Data drive enable |

## Verification
The bench pauses a cell mid-stream by releasing enable, and by lowering enable with the address strobe high. A design that advanced the byte position during a pause would skip bytes. A design that selected itself on any enable-low cycle would drive the bus when it should stay released. The bench also checks the last byte of a cell and the cycle after it. If the cell-available flag drops late, the master sees a phantom second cell. If start-of-cell is misplaced, cell framing is lost. Finally, the bench offers extra source bytes while a cell is held and confirms they never overwrite the stored cell. It also checks that a selected read with no cell drives zero data without a start-of-cell mark.

// File: rtl/utl2_pkg.sv
package utl2_pkg;
  localparam int unsigned CELL_LEN = 53;
  localparam int unsigned BYTE_W   = 8;

  typedef enum logic [1:0] {
    EN_STEADY = 2'd0,
    EN_FALL   = 2'd1,
    EN_RISE   = 2'd2
  } en_edge_e;
endpackage

// File: rtl/utl2_cell_store.sv
module utl2_cell_store #(
  parameter int unsigned CELL_BYTES = utl2_pkg::CELL_LEN,
  parameter int unsigned DATA_W     = utl2_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              rd_adv,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_first,
  output logic              cell_ready
);
  localparam int unsigned PW = $clog2(CELL_BYTES);
  localparam int unsigned CW = $clog2(CELL_BYTES + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(CELL_BYTES - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(CELL_BYTES);

  logic [DATA_W-1:0] mem [CELL_BYTES];
  logic [CW-1:0]     fill_cnt;
  logic [PW-1:0]     rd_ptr;
  logic              wr_fire;

  assign cell_ready = (fill_cnt == FULL_CNT);
  assign wr_ready   = !cell_ready;
  assign wr_fire    = wr_valid && wr_ready;
  assign rd_data    = mem[rd_ptr];
  assign rd_first   = (rd_ptr == '0);

  always_ff @(posedge clk) begin
    if (wr_fire) mem[PW'(fill_cnt)] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      rd_ptr   <= '0;
    end else if (rd_adv && cell_ready) begin
      if (rd_ptr == LAST_IDX) begin
        rd_ptr   <= '0;
        fill_cnt <= '0;
      end else begin
        rd_ptr <= rd_ptr + 1'b1;
      end
    end else if (wr_fire) begin
      fill_cnt <= fill_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/utl2_sel_track.sv
module utl2_sel_track (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_n,
  input  logic enable_n,
  output logic xfer
);
  import utl2_pkg::*;

  logic     en_q;
  logic     sel_q;
  logic     sel_now;
  en_edge_e edge_kind;

  always_comb begin
    if (en_q && !enable_n)      edge_kind = EN_FALL;
    else if (!en_q && enable_n) edge_kind = EN_RISE;
    else                        edge_kind = EN_STEADY;
  end

  assign sel_now = (edge_kind == EN_FALL) ? !addr_n : sel_q;
  assign xfer    = !enable_n && sel_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      sel_q <= 1'b0;
    end else begin
      en_q <= enable_n;
      case (edge_kind)
        EN_FALL: sel_q <= !addr_n;
        EN_RISE: if (addr_n) sel_q <= 1'b0;
        default: sel_q <= sel_q;
      endcase
    end
  end
endmodule

// File: rtl/utl2_cell_tx.sv
module utl2_cell_tx #(
  parameter int unsigned CELL_BYTES = utl2_pkg::CELL_LEN,
  parameter int unsigned DATA_W     = utl2_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic              addr_n,
  input  logic              enable_n,
  output logic              clav_o,
  output logic              clav_oe,
  output logic              soc_o,
  output logic              soc_oe,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe
);
  logic              xfer;
  logic              cell_ready;
  logic              rd_first;
  logic [DATA_W-1:0] rd_data;
  logic              rd_adv;

  assign rd_adv = xfer && cell_ready;

  utl2_sel_track sel_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_n   (addr_n),
    .enable_n (enable_n),
    .xfer     (xfer)
  );

  utl2_cell_store #(
    .CELL_BYTES (CELL_BYTES),
    .DATA_W     (DATA_W)
  ) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data    (src_data),
    .wr_valid   (src_valid),
    .wr_ready   (src_ready),
    .rd_adv     (rd_adv),
    .rd_data    (rd_data),
    .rd_first   (rd_first),
    .cell_ready (cell_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clav_o  <= 1'b0;
      clav_oe <= 1'b0;
      soc_o   <= 1'b0;
      soc_oe  <= 1'b0;
      data_o  <= '0;
      data_oe <= 1'b0;
    end else begin
      clav_oe <= !addr_n;
      clav_o  <= !addr_n && cell_ready;
      data_oe <= xfer;
      soc_oe  <= xfer;
      data_o  <= rd_adv ? rd_data : '0;
      soc_o   <= rd_adv && rd_first;
    end
  end
endmodule

// File: rtl/utl2_cell_tx_chk.sv
module utl2_cell_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_n,
  input logic enable_n,
  input logic clav_o,
  input logic clav_oe,
  input logic soc_o,
  input logic soc_oe,
  input logic data_oe
);
  p_clav_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_n |=> clav_oe);
  p_clav_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_n |=> !clav_oe);
  p_clav_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clav_o |-> clav_oe);
  p_fall_unselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(enable_n) && addr_n) |=> !data_oe);
  p_idle_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enable_n |=> (!data_oe && !soc_oe));
  p_soc_with_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    soc_o |-> data_oe);
endmodule

bind utl2_cell_tx utl2_cell_tx_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr_n   (addr_n),
  .enable_n (enable_n),
  .clav_o   (clav_o),
  .clav_oe  (clav_oe),
  .soc_o    (soc_o),
  .soc_oe   (soc_oe),
  .data_oe  (data_oe)
);

// File: tb/utl2_cell_tx_tb_top.sv
module utl2_cell_tx_tb_top;
  localparam int N = 53;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_data = '0;
  logic       src_valid = 1'b0;
  logic       src_ready;
  logic       addr_n = 1'b1;
  logic       enable_n = 1'b1;
  logic       clav_o, clav_oe, soc_o, soc_oe, data_oe;
  logic [7:0] data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  utl2_cell_tx dut_i (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .addr_n(addr_n), .enable_n(enable_n),
    .clav_o(clav_o), .clav_oe(clav_oe), .soc_o(soc_o), .soc_oe(soc_oe),
    .data_o(data_o), .data_oe(data_oe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // inputs set at a falling edge; outputs read at the next falling edge
  task automatic step(input logic a, input logic e);
    addr_n   = a;
    enable_n = e;
    @(negedge clk);
  endtask

  task automatic load_cell(input logic [7:0] base);
    for (int i = 0; i < N; i++) begin
      chk("R8", "src_ready while filling", src_ready, 1);
      src_valid = 1'b1;
      src_data  = base + 8'(i);
      step(1'b0, 1'b1);
      chk("R2", "clav_o before cell complete", clav_o, 0);
    end
    src_data = ~base;
    step(1'b1, 1'b1);
    chk("R8", "src_ready with cell held", src_ready, 0);
    step(1'b1, 1'b1);
    src_valid = 1'b0;
    chk("R8", "src_ready stays low", src_ready, 0);
  endtask

  task automatic t_reset;
    chk("R9", "clav_oe after reset", clav_oe, 0);
    chk("R9", "data_oe after reset", data_oe, 0);
    chk("R9", "soc_oe after reset", soc_oe, 0);
    chk("R9", "src_ready after reset", src_ready, 1);
  endtask

  task automatic t_poll;
    step(1'b1, 1'b1);
    chk("R1", "clav_oe addr high", clav_oe, 0);
    step(1'b0, 1'b1);
    chk("R1", "clav_oe addr low", clav_oe, 1);
    chk("R2", "clav_o with no cell", clav_o, 0);
    step(1'b1, 1'b1);
    chk("R1", "clav_oe released", clav_oe, 0);
  endtask

  task automatic t_empty_sel;
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R4", "data_oe selected, empty", data_oe, 1);
    chk("R4", "data_o zero, empty", data_o, 0);
    chk("R5", "soc_o low, empty", soc_o, 0);
    step(1'b1, 1'b1);
    chk("R4", "data_oe after release", data_oe, 0);
  endtask

  task automatic t_full_cell(input logic [7:0] base);
    load_cell(base);
    step(1'b0, 1'b1);
    chk("R2", "clav_o with full cell", clav_o, 1);
    chk("R4", "data_oe before select", data_oe, 0);
    step(1'b0, 1'b0);
    chk("R4", "data_oe first byte", data_oe, 1);
    chk("R4", "soc_oe first byte", soc_oe, 1);
    chk("R5", "soc_o first byte", soc_o, 1);
    chk("R6", "byte 0", data_o, 32'(base));
    for (int k = 1; k < N; k++) begin
      step((k == N - 1) ? 1'b0 : 1'b1, 1'b0);
      chk("R6", $sformatf("byte %0d", k), data_o, 32'(8'(base + 8'(k))));
      chk("R5", $sformatf("soc_o byte %0d", k), soc_o, 0);
    end
    chk("R7", "clav_o with last byte", clav_o, 1);
    step(1'b0, 1'b1);
    chk("R7", "clav_o after last byte", clav_o, 0);
    chk("R4", "data_oe after enable high", data_oe, 0);
    chk("R8", "src_ready after cell sent", src_ready, 1);
  endtask

  task automatic t_pause(input logic [7:0] base);
    load_cell(base);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R5", "soc_o first byte", soc_o, 1);
    chk("R6", "byte 0", data_o, 32'(base));
    for (int k = 1; k < 5; k++) begin
      step(1'b1, 1'b0);
      chk("R6", $sformatf("byte %0d", k), data_o, 32'(8'(base + 8'(k))));
    end
    step(1'b0, 1'b1);
    chk("R4", "paused data_oe", data_oe, 0);
    step(1'b1, 1'b0);
    chk("R3", "fall with addr high no drive", data_oe, 0);
    step(1'b1, 1'b0);
    chk("R3", "still unselected", data_oe, 0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    chk("R3", "reselect drives", data_oe, 1);
    chk("R6", "resume byte 5", data_o, 32'(8'(base + 8'd5)));
    chk("R5", "soc_o on resume", soc_o, 0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R6", "resume byte 6", data_o, 32'(8'(base + 8'd6)));
    for (int k = 7; k < N; k++) begin
      step(1'b1, 1'b0);
      chk("R6", $sformatf("byte %0d", k), data_o, 32'(8'(base + 8'(k))));
    end
    step(1'b1, 1'b1);
    chk("R8", "src_ready after paused cell", src_ready, 1);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_poll();
    t_empty_sel();
    t_full_cell(8'h10);
    t_pause(8'h80);
    t_full_cell(8'hC3);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule